// File: doc/BRIEF.md
# Four-Channel Host/Management Mailbox with Buffer-Full Flags

This block is a byte-wide mailbox with four independent channels. It sits between a management controller and a host processor. The management side sees a 32-bit register bus with a byte address and separate read and write strobes. Through that bus it reaches four control words and, for each channel, an inbound data byte, an outbound data byte and a status byte. The host side is a narrow port. On it the host picks a channel and a selector, writes inbound data or commands, and reads outbound data or status.

Each channel tracks two handshake flags. The inbound-full flag tells the management controller that the host has left a byte. The outbound-full flag tells the host that a reply is waiting. Both flags move only as side effects of accesses from the two sides. Each channel has its own enable bits and its own inbound interrupt enable, and they sit in different control words. The third channel needs two enable bits at once. A build-time parameter chooses between two interrupt outputs: one line per channel, or one shared line that is high while any channel interrupt is pending.

Read data on both sides is registered, so it appears on the clock edge after the read strobe.

Top module: `kcs_mailbox`

## Requirements
- R1: After reset every control word, data byte, flag and pending interrupt is zero. All interrupt outputs are low, and reads of any register return zero.
- R2: The control words are read/write at the byte addresses 0x000, 0x008, 0x010 and 0x100 and read back all 32 bits. A read of any other non-channel address returns zero, and a write to such an address changes nothing.
- R3: The host writes inbound data with selector 0 (data port) or selector 2 (command port). The write stores the byte and sets inbound-full, which is status bit 1. It also sets the command/data bit, status bit 3, to 0 for the data port and to 1 for the command port. This happens whether or not the channel is enabled.
- R4: A management read of a channel's inbound address returns the byte in bits 7:0, with zeros above, and clears inbound-full. The inbound addresses are 0x024, 0x028, 0x02C and 0x114. Management writes to these addresses have no effect.
- R5: A management write to a channel's outbound address keeps the low byte and sets outbound-full, which is status bit 0. The outbound addresses are 0x030, 0x034, 0x038 and 0x118. A host read with selector 0 returns that byte and clears outbound-full.
- R6: Host selector 1 reads the channel status byte. Host writes with selector 1 are ignored.
- R7: A host inbound write raises that channel's interrupt only when the channel is enabled and its inbound interrupt enable is set. The enables are: channel 0 at bit 5 of word 0x000 with its interrupt enable at bit 1 of 0x008; channel 1 at bit 6 of 0x000 with bit 2 of 0x008; channel 3 at bit 0 of 0x100 with bit 1 of 0x100.
- R8: Channel 2 is enabled only when bit 7 of 0x000 and bit 2 of 0x010 are both set. Its interrupt enable is bit 3 of 0x008.
- R9: A raised channel interrupt stays high until a management read of that channel's inbound address while inbound-full is set. That read lowers it.
- R10: If a host inbound write and a management inbound read hit the same channel in the same cycle, the host write wins. The new byte is kept, inbound-full stays set and the interrupt stays as it was. The read returns the previous byte.
- R11: With SHARED_IRQ=0 each channel interrupt drives its own output bit and the shared output stays low. With SHARED_IRQ=1 the per-channel outputs stay low and the shared output is high while any channel interrupt is pending.
- R12: A management write to a status address (0x03C, 0x040, 0x044, 0x11C) updates status bits 7:2 only. The two buffer-full flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bmcAddr | input | 12 | Management byte address |
| bmcWrEn | input | 1 | Management write strobe |
| bmcRdEn | input | 1 | Management read strobe |
| bmcWrData | input | 32 | Management write data |
| bmcRdData | output | 32 | Management read data, one cycle after the strobe |
| hostChan | input | 2 | Host channel select |
| hostSel | input | 2 | Host selector: 0 data, 1 status, 2 command |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, one cycle after the strobe |
| irqChan | output | 4 | Per-channel interrupts (SHARED_IRQ=0) |
| irqShared | output | 1 | Combined interrupt (SHARED_IRQ=1) |

## Verification
Suppose a buffer-full flag is held in the wrong state. The next status read on either side shows it one cycle after the strobe, so the bench reads status after every flag-changing access. A lost or stuck interrupt bit shows on irqChan or irqShared right after the access that should have changed it. Wrong enable decoding, such as channel 2 needing only one of its two bits, shows as an interrupt after a host write that should have stayed quiet. The same-cycle collision is visible at once: the read returns the old byte, and the status read that follows still shows inbound-full.

// File: rtl/kcs_mailbox_pkg.sv
package kcs_mailbox_pkg;
  localparam int NUM_CHAN   = 4;
  localparam int CHAN_W     = $clog2(NUM_CHAN);
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int NUM_CTRL   = 4;
  localparam int CTRL_IDX_W = $clog2(NUM_CTRL);

  // control word slots
  localparam int CW0 = 0;
  localparam int CW2 = 1;
  localparam int CW4 = 2;
  localparam int CWB = 3;

  // enable bit positions
  localparam int EN0_BIT  = 5;
  localparam int EN1_BIT  = 6;
  localparam int EN2A_BIT = 7;
  localparam int EN2B_BIT = 2;
  localparam int EN3_BIT  = 0;
  localparam int IE0_BIT  = 1;
  localparam int IE1_BIT  = 2;
  localparam int IE2_BIT  = 3;
  localparam int IE3_BIT  = 1;

  // host selector codes
  localparam logic [1:0] HSEL_DATA = 2'd0;
  localparam logic [1:0] HSEL_STS  = 2'd1;
  localparam logic [1:0] HSEL_CMD  = 2'd2;

  typedef enum logic [2:0] {RD_NONE, RD_CTRL, RD_IDR, RD_ODR, RD_STS} rdSel_e;

  typedef struct packed {
    logic [NUM_CTRL-1:0] ctrlWr;
    logic [NUM_CHAN-1:0] idrRd;
    logic [NUM_CHAN-1:0] odrWr;
    logic [NUM_CHAN-1:0] stsWr;
    logic [NUM_CHAN-1:0] hostIdrWr;
    logic [NUM_CHAN-1:0] hostOdrRd;
    logic                hostCmd;
    logic                hostStsRd;
    logic [CHAN_W-1:0]   hostIdx;
    rdSel_e              rdSel;
    logic [CHAN_W-1:0]   rdIdx;
  } kcsStrobe_t;

  function automatic logic [ADDR_W-1:0] ctrlAddr(input int i);
    case (i)
      0:       return ADDR_W'('h000);
      1:       return ADDR_W'('h008);
      2:       return ADDR_W'('h010);
      default: return ADDR_W'('h100);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] idrAddr(input int c);
    return (c < 3) ? ADDR_W'('h024 + 4 * c) : ADDR_W'('h114);
  endfunction

  function automatic logic [ADDR_W-1:0] odrAddr(input int c);
    return (c < 3) ? ADDR_W'('h030 + 4 * c) : ADDR_W'('h118);
  endfunction

  function automatic logic [ADDR_W-1:0] stsAddr(input int c);
    return (c < 3) ? ADDR_W'('h03C + 4 * c) : ADDR_W'('h11C);
  endfunction
endpackage

// File: rtl/kcs_mbx_ctrl.sv
module kcs_mbx_ctrl
  import kcs_mailbox_pkg::*;
(
  input  logic [ADDR_W-1:0] bmcAddr,
  input  logic              bmcWrEn,
  input  logic              bmcRdEn,
  input  logic [CHAN_W-1:0] hostChan,
  input  logic [1:0]        hostSel,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  output kcsStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    strobe.hostIdx = hostChan;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (bmcAddr == ctrlAddr(i)) begin
        strobe.ctrlWr[i] = bmcWrEn;
        if (bmcRdEn) begin
          strobe.rdSel = RD_CTRL;
          strobe.rdIdx = CHAN_W'(i);
        end
      end
    end
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (bmcAddr == idrAddr(c) && bmcRdEn) begin
        strobe.idrRd[c] = 1'b1;
        strobe.rdSel = RD_IDR;
        strobe.rdIdx = CHAN_W'(c);
      end
      if (bmcAddr == odrAddr(c)) begin
        strobe.odrWr[c] = bmcWrEn;
        if (bmcRdEn) begin
          strobe.rdSel = RD_ODR;
          strobe.rdIdx = CHAN_W'(c);
        end
      end
      if (bmcAddr == stsAddr(c)) begin
        strobe.stsWr[c] = bmcWrEn;
        if (bmcRdEn) begin
          strobe.rdSel = RD_STS;
          strobe.rdIdx = CHAN_W'(c);
        end
      end
    end
    if (hostWrEn && (hostSel == HSEL_DATA || hostSel == HSEL_CMD)) begin
      strobe.hostIdrWr[hostChan] = 1'b1;
      strobe.hostCmd = (hostSel == HSEL_CMD);
    end
    if (hostRdEn && hostSel == HSEL_DATA) strobe.hostOdrRd[hostChan] = 1'b1;
    if (hostRdEn && hostSel == HSEL_STS)  strobe.hostStsRd = 1'b1;
  end
endmodule

// File: rtl/kcs_mbx_datapath.sv
module kcs_mbx_datapath
  import kcs_mailbox_pkg::*;
#(
  parameter bit SHARED_IRQ = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  kcsStrobe_t          strobe,
  input  logic [WORD_W-1:0]   bmcWrData,
  input  logic [BYTE_W-1:0]   hostWrData,
  output logic [WORD_W-1:0]   bmcRdData,
  output logic [BYTE_W-1:0]   hostRdData,
  output logic [NUM_CHAN-1:0] irqChan,
  output logic                irqShared,
  output logic [NUM_CHAN-1:0] ibfFlag,
  output logic [NUM_CHAN-1:0] obfFlag,
  output logic [NUM_CHAN-1:0] chanIrq
);
  logic [WORD_W-1:0] ctrlReg [NUM_CTRL];
  logic [NUM_CHAN-1:0] chanEn, ibfIe;
  logic [NUM_CHAN-1:0][BYTE_W-1:0] idrByte, odrByte, stsByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CTRL; i++) ctrlReg[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (strobe.ctrlWr[i]) ctrlReg[i] <= bmcWrData;
    end
  end

  assign chanEn[0] = ctrlReg[CW0][EN0_BIT];
  assign chanEn[1] = ctrlReg[CW0][EN1_BIT];
  assign chanEn[2] = ctrlReg[CW0][EN2A_BIT] & ctrlReg[CW4][EN2B_BIT];
  assign chanEn[3] = ctrlReg[CWB][EN3_BIT];
  assign ibfIe[0]  = ctrlReg[CW2][IE0_BIT];
  assign ibfIe[1]  = ctrlReg[CW2][IE1_BIT];
  assign ibfIe[2]  = ctrlReg[CW2][IE2_BIT];
  assign ibfIe[3]  = ctrlReg[CWB][IE3_BIT];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic [BYTE_W-1:0] idrQ, odrQ;
    logic [BYTE_W-3:0] userQ;  // status bits 7:2, userQ[1] is command/data
    logic ibfQ, obfQ, irqQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idrQ <= '0; odrQ <= '0; userQ <= '0;
        ibfQ <= 1'b0; obfQ <= 1'b0; irqQ <= 1'b0;
      end else begin
        if (strobe.stsWr[c]) userQ <= bmcWrData[BYTE_W-1:2];
        if (strobe.hostIdrWr[c]) begin
          idrQ     <= hostWrData;
          ibfQ     <= 1'b1;
          userQ[1] <= strobe.hostCmd;
          if (chanEn[c] && ibfIe[c]) irqQ <= 1'b1;
        end else if (strobe.idrRd[c]) begin
          ibfQ <= 1'b0;
          if (ibfQ) irqQ <= 1'b0;
        end
        if (strobe.odrWr[c]) begin
          odrQ <= bmcWrData[BYTE_W-1:0];
          obfQ <= 1'b1;
        end else if (strobe.hostOdrRd[c]) begin
          obfQ <= 1'b0;
        end
      end
    end

    assign idrByte[c] = idrQ;
    assign odrByte[c] = odrQ;
    assign stsByte[c] = {userQ, ibfQ, obfQ};
    assign ibfFlag[c] = ibfQ;
    assign obfFlag[c] = obfQ;
    assign chanIrq[c] = irqQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bmcRdData  <= '0;
      hostRdData <= '0;
    end else begin
      case (strobe.rdSel)
        RD_CTRL: bmcRdData <= ctrlReg[strobe.rdIdx];
        RD_IDR:  bmcRdData <= {{(WORD_W-BYTE_W){1'b0}}, idrByte[strobe.rdIdx]};
        RD_ODR:  bmcRdData <= {{(WORD_W-BYTE_W){1'b0}}, odrByte[strobe.rdIdx]};
        RD_STS:  bmcRdData <= {{(WORD_W-BYTE_W){1'b0}}, stsByte[strobe.rdIdx]};
        default: bmcRdData <= '0;
      endcase
      if (|strobe.hostOdrRd)    hostRdData <= odrByte[strobe.hostIdx];
      else if (strobe.hostStsRd) hostRdData <= stsByte[strobe.hostIdx];
      else                       hostRdData <= '0;
    end
  end

  if (SHARED_IRQ) begin : g_shared
    assign irqChan   = '0;
    assign irqShared = |chanIrq;
  end else begin : g_perchan
    assign irqChan   = chanIrq;
    assign irqShared = 1'b0;
  end
endmodule

// File: rtl/kcs_mailbox.sv
module kcs_mailbox
  import kcs_mailbox_pkg::*;
#(
  parameter bit SHARED_IRQ = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   bmcAddr,
  input  logic                bmcWrEn,
  input  logic                bmcRdEn,
  input  logic [WORD_W-1:0]   bmcWrData,
  output logic [WORD_W-1:0]   bmcRdData,
  input  logic [CHAN_W-1:0]   hostChan,
  input  logic [1:0]          hostSel,
  input  logic                hostWrEn,
  input  logic                hostRdEn,
  input  logic [BYTE_W-1:0]   hostWrData,
  output logic [BYTE_W-1:0]   hostRdData,
  output logic [NUM_CHAN-1:0] irqChan,
  output logic                irqShared
);
  kcsStrobe_t strobe;
  logic [NUM_CHAN-1:0] ibfFlag, obfFlag, chanIrq;

  kcs_mbx_ctrl u_ctrl (
    .bmcAddr(bmcAddr), .bmcWrEn(bmcWrEn), .bmcRdEn(bmcRdEn),
    .hostChan(hostChan), .hostSel(hostSel), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .strobe(strobe)
  );

  kcs_mbx_datapath #(.SHARED_IRQ(SHARED_IRQ)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bmcWrData(bmcWrData), .hostWrData(hostWrData),
    .bmcRdData(bmcRdData), .hostRdData(hostRdData),
    .irqChan(irqChan), .irqShared(irqShared),
    .ibfFlag(ibfFlag), .obfFlag(obfFlag), .chanIrq(chanIrq)
  );
endmodule

// File: rtl/kcs_mailbox_chk.sv
module kcs_mailbox_chk
  import kcs_mailbox_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input kcsStrobe_t          strobe,
  input logic [NUM_CHAN-1:0] ibfFlag,
  input logic [NUM_CHAN-1:0] obfFlag,
  input logic [NUM_CHAN-1:0] chanIrq
);
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chk
    AST_IBF_ON_HOST_WR: assert property (@(posedge clk) disable iff (!rstN)
      strobe.hostIdrWr[c] |=> ibfFlag[c]); // R3
    AST_IBF_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
      strobe.idrRd[c] && !strobe.hostIdrWr[c] |=> !ibfFlag[c] && !chanIrq[c]); // R4
    AST_OBF_ON_BMC_WR: assert property (@(posedge clk) disable iff (!rstN)
      strobe.odrWr[c] |=> obfFlag[c]); // R5
    AST_OBF_CLR_ON_HOST_RD: assert property (@(posedge clk) disable iff (!rstN)
      strobe.hostOdrRd[c] && !strobe.odrWr[c] |=> !obfFlag[c]); // R5
    AST_IRQ_NEEDS_IBF: assert property (@(posedge clk) disable iff (!rstN)
      chanIrq[c] |-> ibfFlag[c]); // R9
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      chanIrq[c] && !strobe.idrRd[c] |=> chanIrq[c]); // R9
    AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.hostIdrWr[c] && strobe.idrRd[c] |=> ibfFlag[c]); // R10
  end
endmodule

bind kcs_mailbox kcs_mailbox_chk u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe),
  .ibfFlag(ibfFlag), .obfFlag(obfFlag), .chanIrq(chanIrq)
);

// File: tb/kcs_mailbox_tb.sv
module kcs_mailbox_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] bmcAddr = '0;
  logic bmcWrEn = 1'b0, bmcRdEn = 1'b0;
  logic [31:0] bmcWrData = '0;
  logic [1:0] hostChan = '0, hostSel = '0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [31:0] bmcRdData, bmcRdDataS;
  logic [7:0] hostRdData, hostRdDataS;
  logic [3:0] irqChan, irqChanS;
  logic irqShared, irqSharedS;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // scoreboard queues: kind 0 bmc read, 1 host read, 2 irqChan, 3 shared irq
  int qKind[$];
  logic [31:0] qExp[$];
  string qTag[$];

  always #5 clk = ~clk;

  kcs_mailbox #(.SHARED_IRQ(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .bmcAddr(bmcAddr), .bmcWrEn(bmcWrEn), .bmcRdEn(bmcRdEn),
    .bmcWrData(bmcWrData), .bmcRdData(bmcRdData), .hostChan(hostChan), .hostSel(hostSel),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .irqChan(irqChan), .irqShared(irqShared)
  );

  kcs_mailbox #(.SHARED_IRQ(1'b1)) u_dutShared (
    .clk(clk), .rstN(rstN), .bmcAddr(bmcAddr), .bmcWrEn(bmcWrEn), .bmcRdEn(bmcRdEn),
    .bmcWrData(bmcWrData), .bmcRdData(bmcRdDataS), .hostChan(hostChan), .hostSel(hostSel),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostWrData(hostWrData),
    .hostRdData(hostRdDataS), .irqChan(irqChanS), .irqShared(irqSharedS)
  );

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    qKind.push_back(kind);
    qExp.push_back(exp);
    qTag.push_back(tag);
  endtask

  // monitor: compares pending expectations away from the active edge
  always @(negedge clk) begin
    while (qKind.size() > 0) begin
      int kind;
      logic [31:0] exp, act;
      string tag;
      kind = qKind.pop_front();
      exp = qExp.pop_front();
      tag = qTag.pop_front();
      case (kind)
        0: act = bmcRdData;
        1: act = {24'h0, hostRdData};
        2: act = {28'h0, irqChan} | {27'h0, irqShared, 4'h0};
        default: act = {28'h0, irqChanS} | {27'h0, irqSharedS, 4'h0};
      endcase
      nChecks++;
      if (act !== exp) begin
        nFail++;
        $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
    end
  end

  task automatic clearStrobes();
    bmcWrEn = 1'b0; bmcRdEn = 1'b0; hostWrEn = 1'b0; hostRdEn = 1'b0;
  endtask

  task automatic bmcWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bmcAddr = a; bmcWrData = d; bmcWrEn = 1'b1;
    @(posedge clk); #1;
    clearStrobes();
  endtask

  task automatic bmcRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bmcAddr = a; bmcRdEn = 1'b1;
    @(posedge clk); #1;
    push(0, exp, tag);
    clearStrobes();
  endtask

  task automatic hostWrite(input logic [1:0] ch, input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    hostChan = ch; hostSel = sel; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    clearStrobes();
  endtask

  task automatic hostRead(input logic [1:0] ch, input logic [1:0] sel,
                          input logic [7:0] exp, input string tag);
    @(negedge clk);
    hostChan = ch; hostSel = sel; hostRdEn = 1'b1;
    @(posedge clk); #1;
    push(1, {24'h0, exp}, tag);
    clearStrobes();
  endtask

  // per-channel instance and shared instance, checked against current state
  task automatic expectIrq(input logic [3:0] pend, input string tag);
    push(2, {28'h0, pend}, {tag, " per-channel"});
    push(3, {27'h0, |pend, 4'h0}, {tag, " shared"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    expectIrq(4'h0, "R1 irq after reset");
    bmcRead(12'h000, 32'h0, "R1 control word zero");
    bmcRead(12'h03C, 32'h0, "R1 status zero");
    hostRead(2'd0, 2'd1, 8'h00, "R1 host status zero");

    // R2: control words and undecoded space
    bmcWrite(12'h000, 32'hDEAD_BEE0);
    bmcRead(12'h000, 32'hDEAD_BEE0, "R2 word 0x000 readback");
    bmcWrite(12'h100, 32'h0000_0003);
    bmcRead(12'h100, 32'h0000_0003, "R2 word 0x100 readback");
    bmcWrite(12'h00C, 32'h5555_5555);
    bmcRead(12'h00C, 32'h0, "R2 undecoded reads zero");
    bmcRead(12'h000, 32'hDEAD_BEE0, "R2 undecoded write no effect");
    bmcWrite(12'h000, 32'h0000_00E0);

    // R3/R4: data port write then management read
    hostWrite(2'd0, 2'd0, 8'hA5);
    bmcRead(12'h03C, 32'h02, "R3 inbound-full set");
    expectIrq(4'h0, "R7 no irq without interrupt enable");
    bmcWrite(12'h024, 32'h0000_00FF);
    bmcRead(12'h024, 32'hA5, "R4 inbound byte, write ignored");
    bmcRead(12'h03C, 32'h00, "R4 inbound-full cleared");

    // R3: command port sets command/data bit
    hostWrite(2'd1, 2'd2, 8'h61);
    bmcRead(12'h040, 32'h0A, "R3 command port status");

    // R8: channel 2 needs both enable bits
    bmcWrite(12'h008, 32'h0000_000E);
    hostWrite(2'd2, 2'd0, 8'h44);
    expectIrq(4'h0, "R8 single enable bit no irq");
    bmcRead(12'h02C, 32'h44, "R8 read channel 2");
    bmcWrite(12'h010, 32'h0000_0004);
    hostWrite(2'd2, 2'd0, 8'h33);
    expectIrq(4'h4, "R8 R11 both bits raise irq");
    bmcRead(12'h02C, 32'h33, "R9 read channel 2 data");
    expectIrq(4'h0, "R9 irq lowered by read");

    // R7: channel 3 enables in word 0x100
    hostWrite(2'd3, 2'd0, 8'h77);
    expectIrq(4'h8, "R7 channel 3 irq");
    bmcWrite(12'h100, 32'h0000_0002);
    expectIrq(4'h8, "R9 irq holds after enable change");
    bmcRead(12'h114, 32'h77, "R9 channel 3 data");
    expectIrq(4'h0, "R9 channel 3 irq lowered");

    // R10: same-cycle host write and management read
    hostWrite(2'd0, 2'd0, 8'h11);
    expectIrq(4'h1, "R7 channel 0 irq");
    @(negedge clk);
    hostChan = 2'd0; hostSel = 2'd0; hostWrData = 8'h22; hostWrEn = 1'b1;
    bmcAddr = 12'h024; bmcRdEn = 1'b1;
    @(posedge clk); #1;
    push(0, 32'h11, "R10 read returns old byte");
    clearStrobes();
    expectIrq(4'h1, "R10 irq stays raised");
    bmcRead(12'h03C, 32'h02, "R10 inbound-full stays");
    bmcRead(12'h024, 32'h22, "R10 new byte kept");
    expectIrq(4'h0, "R9 irq lowered after final read");

    // R5: outbound path
    bmcWrite(12'h030, 32'hFFFF_FF3C);
    bmcRead(12'h03C, 32'h01, "R5 outbound-full set");
    bmcRead(12'h030, 32'h3C, "R5 outbound low byte only");
    hostRead(2'd0, 2'd0, 8'h3C, "R5 host reads outbound byte");
    bmcRead(12'h03C, 32'h00, "R5 outbound-full cleared");

    // R6: host status writes ignored
    hostWrite(2'd0, 2'd1, 8'hFF);
    hostRead(2'd0, 2'd1, 8'h00, "R6 status write ignored");
    hostRead(2'd1, 2'd1, 8'h0A, "R6 host status read channel 1");

    // R12: management status write touches bits 7:2
    bmcWrite(12'h03C, 32'h0000_00FF);
    bmcRead(12'h03C, 32'hFC, "R12 flags untouched");

    // R7: disabled channel with interrupt enable set
    bmcWrite(12'h000, 32'h0);
    hostWrite(2'd0, 2'd0, 8'h99);
    expectIrq(4'h0, "R7 disabled channel no irq");
    bmcRead(12'h03C, 32'hF6, "R3 flag set while disabled");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule